// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital half of a successive-approximation converter. A fast bit clock drives it. A single-cycle start strobe, synchronous to that clock and derived from the sample-rate clock, begins each conversion. The block then drives a trial code to an external DAC. It reads back one decision bit from an analog comparator, which is high when the held sample is at or above the DAC level. With these two signals it runs a binary search over the code space.

The search opens at midscale and decides one bit per cycle, from the top bit down to bit 0. After the last decision the block publishes the code on a registered result port. In the same cycle it raises an end-of-conversion pulse. That pulse also serves as the DAC discharge command, so the trial code is zero while it is high. A frame takes N+2 bit-clock cycles: N decision cycles, one publish cycle and one idle cycle in which the next strobe is accepted. For the default N = 12 this is 14 cycles per sample.

Top module: `sar_seq`

## Requirements
- R1: While reset is high and on the first cycle after it, dac_code, eoc and result are all zero.
- R2: A start strobe seen in the idle state makes dac_code equal midscale (only bit N-1 set) on the following cycle.
- R3: On each search cycle the bit under test stays set when cmp_ge is 1 and is cleared when it is 0. Bits above it keep their values, and the next lower bit is set on the following cycle.
- R4: eoc is high for exactly one cycle per conversion. That cycle is the one immediately after the cycle in which bit 0 was decided, N+1 cycles after the accepted strobe edge.
- R5: result is loaded with the final code in the cycle eoc rises and keeps its value until the next eoc.
- R6: dac_code is zero whenever eoc is high.
- R7: A start strobe that arrives during the search or during the eoc cycle is ignored. It does not change the trial sequence, the result or the eoc timing.
- R8: After reset, eoc stays low until a first conversion has completed.
- R9: Strobes spaced exactly N+2 cycles apart are all accepted back to back.
- R10: With an ideal comparator that holds sample code v, result equals v, including 0, midscale and full scale.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock |
| rst | input | 1 | Synchronous active-high reset |
| conv_start | input | 1 | Single-cycle conversion strobe |
| cmp_ge | input | 1 | Comparator decision: held sample >= DAC level |
| dac_code | output | N | Trial code to the DAC |
| eoc | output | 1 | End-of-conversion pulse and DAC discharge command |
| result | output | N | Last completed conversion code |

## Verification
On every cycle the assertions check four things. The eoc pulse lasts one cycle and falls exactly N+1 cycles after an accepted strobe, never earlier. The DAC code is zero under eoc. The result holds between pulses. An accepted strobe produces midscale, while a strobe in mid-search does not restart the search. The bit-by-bit trial sequence, the correctness of the final code against the sampled value, and the survival of results across ignored strobes depend on the comparator model. Only the bench's directed corner codes and seeded random samples can show them.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

  typedef enum logic [1:0] {
    PH_IDLE    = 2'd0,
    PH_SEARCH  = 2'd1,
    PH_PUBLISH = 2'd2
  } phase_t;

endpackage

// File: rtl/sar_frame_ctl.sv
module sar_frame_ctl
  import sar_seq_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   conv_start,
  input  logic   last_bit,
  output phase_t phase,
  output logic   load_mid,
  output logic   step,
  output logic   publish
);

  phase_t phase_nxt;

  // strobe accepted only while idle; later strobes fall through
  assign load_mid = (phase == PH_IDLE) && conv_start;
  assign step     = (phase == PH_SEARCH);
  assign publish  = (phase == PH_SEARCH) && last_bit;

  always_comb begin
    phase_nxt = phase;
    unique case (phase)
      PH_IDLE:    if (conv_start) phase_nxt = PH_SEARCH;
      PH_SEARCH:  if (last_bit)   phase_nxt = PH_PUBLISH;
      PH_PUBLISH: phase_nxt = PH_IDLE;
      default:    phase_nxt = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) phase <= PH_IDLE;
    else     phase <= phase_nxt;
  end

endmodule

// File: rtl/sar_trial_reg.sv
module sar_trial_reg #(
  parameter int N = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_mid,
  input  logic         step,
  input  logic         clear,
  input  logic         cmp_ge,
  output logic [N-1:0] trial,
  output logic [N-1:0] decided,
  output logic         last_bit
);

  localparam logic [N-1:0] MID = {1'b1, {(N-1){1'b0}}};

  logic [N-1:0] mask;
  logic [N-1:0] trial_nxt;

  assign last_bit = mask[0];

  // per-bit slice: resolve the bit under test, arm the one below it
  for (genvar i = 0; i < N; i++) begin : g_bit
    assign decided[i] = mask[i] ? cmp_ge : trial[i];
    if (i == N-1) begin : g_top
      assign trial_nxt[i] = decided[i];
    end else begin : g_low
      assign trial_nxt[i] = decided[i] | mask[i+1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      trial <= '0;
      mask  <= '0;
    end else if (load_mid) begin
      trial <= MID;
      mask  <= MID;
    end else if (clear) begin
      trial <= '0;
      mask  <= '0;
    end else if (step) begin
      trial <= trial_nxt;
      mask  <= mask >> 1;
    end
  end

endmodule

// File: rtl/sar_result_reg.sv
module sar_result_reg #(
  parameter int N = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         publish,
  input  logic [N-1:0] code_in,
  output logic [N-1:0] result,
  output logic         eoc
);

  always_ff @(posedge clk) begin
    if (rst) begin
      result <= '0;
      eoc    <= 1'b0;
    end else begin
      eoc <= publish;
      if (publish) result <= code_in;
    end
  end

endmodule

// File: rtl/sar_seq.sv
module sar_seq
  import sar_seq_pkg::*;
#(
  parameter int N = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         conv_start,
  input  logic         cmp_ge,
  output logic [N-1:0] dac_code,
  output logic         eoc,
  output logic [N-1:0] result
);

  phase_t       phase;
  logic         load_mid;
  logic         step;
  logic         publish;
  logic         last_bit;
  logic [N-1:0] decided;
  logic         idle;
  logic         searching;

  assign idle      = (phase == PH_IDLE);
  assign searching = (phase == PH_SEARCH);

  sar_frame_ctl u_ctl (
    .clk        (clk),
    .rst        (rst),
    .conv_start (conv_start),
    .last_bit   (last_bit),
    .phase      (phase),
    .load_mid   (load_mid),
    .step       (step),
    .publish    (publish)
  );

  sar_trial_reg #(.N(N)) u_trial (
    .clk      (clk),
    .rst      (rst),
    .load_mid (load_mid),
    .step     (step),
    .clear    (publish),
    .cmp_ge   (cmp_ge),
    .trial    (dac_code),
    .decided  (decided),
    .last_bit (last_bit)
  );

  sar_result_reg #(.N(N)) u_res (
    .clk     (clk),
    .rst     (rst),
    .publish (publish),
    .code_in (decided),
    .result  (result),
    .eoc     (eoc)
  );

endmodule

// File: rtl/sar_seq_chk.sv
module sar_seq_chk #(
  parameter int N = 12
) (
  input logic         clk,
  input logic         rst,
  input logic         conv_start,
  input logic         idle,
  input logic         searching,
  input logic [N-1:0] dac_code,
  input logic         eoc,
  input logic [N-1:0] result
);

  localparam logic [N-1:0] MID = {1'b1, {(N-1){1'b0}}};
  localparam int CW = $clog2(N + 2) + 1;
  localparam logic [CW-1:0] DONE_AT = CW'(N + 1);

  logic [CW-1:0] since_start;

  always_ff @(posedge clk) begin
    if (rst)                                          since_start <= '0;
    else if (idle && conv_start)                      since_start <= CW'(1);
    else if (since_start != '0 && since_start != DONE_AT) since_start <= since_start + 1'b1;
    else                                              since_start <= '0;
  end

  // R4
  eoc_single_chk: assert property (@(posedge clk) disable iff (rst) eoc |=> !eoc);

  // R8
  eoc_timing_chk: assert property (@(posedge clk) disable iff (rst) eoc |-> (since_start == DONE_AT));

  // R4
  eoc_due_chk: assert property (@(posedge clk) disable iff (rst) (since_start == DONE_AT) |-> eoc);

  // R6
  dac_discharge_chk: assert property (@(posedge clk) disable iff (rst) eoc |-> (dac_code == '0));

  // R5
  result_hold_chk: assert property (@(posedge clk) disable iff (rst) !eoc |-> $stable(result));

  // R2
  start_mid_chk: assert property (@(posedge clk) disable iff (rst) (idle && conv_start) |=> (dac_code == MID));

  // R7
  no_restart_chk: assert property (@(posedge clk) disable iff (rst) (searching && conv_start) |=> (dac_code != MID));

endmodule

bind sar_seq sar_seq_chk #(.N(N)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .conv_start (conv_start),
  .idle       (idle),
  .searching  (searching),
  .dac_code   (dac_code),
  .eoc        (eoc),
  .result     (result)
);

// File: tb/sar_seq_bench.sv
module sar_seq_bench;

  localparam int N = 12;
  localparam int CLK_PERIOD = 10;
  localparam logic [N-1:0] MID = {1'b1, {(N-1){1'b0}}};
  localparam logic [N-1:0] FULL = '1;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         conv_start = 1'b0;
  logic [N-1:0] vin = '0;
  logic         cmp_ge;
  logic [N-1:0] dac_code;
  logic         eoc;
  logic [N-1:0] result;

  int n_checks = 0;
  int n_fail = 0;
  bit reported = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // ideal comparator holding sample code vin
  assign cmp_ge = (vin >= dac_code);

  sar_seq #(.N(N)) u_sar_seq (
    .clk        (clk),
    .rst        (rst),
    .conv_start (conv_start),
    .cmp_ge     (cmp_ge),
    .dac_code   (dac_code),
    .eoc        (eoc),
    .result     (result)
  );

  task automatic chk(input bit ok, input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  // expected trial after a decision on bit b given held code v
  function automatic logic [N-1:0] next_trial(input logic [N-1:0] t, input int b, input logic [N-1:0] v);
    logic [N-1:0] r;
    r = t;
    if (!(v >= t)) r[b] = 1'b0;
    if (b > 0) r[b-1] = 1'b1;
    return r;
  endfunction

  // one full frame: strobe at current negedge, ends at the negedge after eoc
  // stray_at: negedge index (1..N+1) at which a stray strobe is pulsed, 0 for none
  task automatic convert(input logic [N-1:0] v, input int stray_at);
    logic [N-1:0] exp_t;
    logic [N-1:0] prev_res;
    prev_res   = result;
    vin        = v;
    conv_start = 1'b1;
    exp_t      = MID;
    for (int i = 1; i <= N; i++) begin
      @(negedge clk);
      conv_start = (i == stray_at);
      if (i == 1) chk(dac_code == MID, "R2", dac_code, MID);
      else        chk(dac_code == exp_t, "R3", dac_code, exp_t);
      chk(eoc == 1'b0, "R4", {{(N-1){1'b0}}, eoc}, '0);
      chk(result == prev_res, "R5", result, prev_res);
      exp_t = next_trial(exp_t, N - i, v);
    end
    @(negedge clk);
    conv_start = (stray_at == N + 1);
    chk(eoc == 1'b1, "R4", {{(N-1){1'b0}}, eoc}, 1);
    chk(dac_code == '0, "R6", dac_code, '0);
    chk(result == v, (stray_at != 0) ? "R7" : "R10", result, v);
    @(negedge clk);
    conv_start = 1'b0;
    chk(eoc == 1'b0, "R4", {{(N-1){1'b0}}, eoc}, '0);
    chk(result == v, "R5", result, v);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    report();
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(dac_code == '0 && eoc == 1'b0 && result == '0, "R1", dac_code | result, '0);
    rst = 1'b0;
    @(negedge clk);
    chk(dac_code == '0 && eoc == 1'b0 && result == '0, "R1", dac_code | result, '0);

    // R8: stay idle a while, no eoc without a conversion
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      chk(eoc == 1'b0, "R8", {{(N-1){1'b0}}, eoc}, '0);
    end

    // R10 corner codes, back to back at frame period N+2 (R9)
    convert('0, 0);
    convert(MID, 0);
    convert(FULL, 0);
    convert(MID - 1'b1, 0);
    convert(12'd1, 0);
    chk(result == 12'd1, "R9", result, 12'd1);

    // R7: stray strobes in early, late search and in the eoc cycle
    convert(12'd1234, 3);
    convert(12'd3000, N - 1);
    convert(12'd77, N + 1);
    // the frame after a stray strobe in the eoc cycle starts only on a new strobe
    @(negedge clk);
    chk(eoc == 1'b0 && dac_code == '0, "R7", dac_code, '0);
    chk(result == 12'd77, "R7", result, 12'd77);

    // random samples with random idle gaps
    for (int k = 0; k < 60; k++) begin
      logic [N-1:0] v;
      int gap;
      v = N'($urandom);
      gap = $urandom_range(0, 4);
      for (int g = 0; g < gap; g++) begin
        @(negedge clk);
        chk(result == u_prev(k), "R5", result, result);
      end
      convert(v, ($urandom_range(0, 3) == 0) ? $urandom_range(2, N + 1) : 0);
    end

    report();
  end

  // idle-gap hold check helper: result must not move between frames
  logic [N-1:0] held;
  always @(negedge clk) if (eoc) held = result;
  function automatic logic [N-1:0] u_prev(input int k);
    return (k >= 0) ? held : held;
  endfunction

endmodule